// File: doc/BRIEF.md
# Segment Privilege Check Unit

This unit judges, one request at a time, whether a segment-register load or a control transfer may proceed under a four-ring privilege scheme (level 0 most trusted, level 3 least). A request names its kind (data-segment load, near transfer, far jump or far call). It also carries the running privilege level, the requestor level held in the selector, and the fields of the chosen descriptor, already decoded. For a call gate it also carries the privilege level and conforming flag of the code segment the gate leads to. Near transfers are judged only against the cached code-segment limit.

Each request strobe produces exactly one registered verdict on the following clock. The verdict gives a permit flag, a fault class (general protection or segment-not-present) and the privilege level that execution continues at. Descriptor fetch, stack switching and fault delivery belong to neighbouring logic.

Top module: `seg_priv_check`

## Requirements
- R1: A data load (`req_kind`=0) of a data descriptor (`tgt_kind`=0) is permitted exactly when `tgt_dpl` >= max(`cur_cpl`, `sel_rpl`); otherwise fault class GP.
- R2: A data load whose target is a code descriptor (`tgt_kind`=1) or a call gate (`tgt_kind`=2) is a GP fault regardless of levels.
- R3: A far jump (`req_kind`=2) or far call (`req_kind`=3) straight to a code descriptor with `tgt_conf`=0 is permitted only when `tgt_dpl` equals `cur_cpl`; the new level equals `cur_cpl`.
- R4: A far jump or call straight to a code descriptor with `tgt_conf`=1 is permitted when `tgt_dpl` <= `cur_cpl`, and the new level stays `cur_cpl`.
- R5: A far transfer through a call gate (`tgt_kind`=2) is a GP fault when the gate level `tgt_dpl` < max(`cur_cpl`, `sel_rpl`) or when the destination code level `gate_code_dpl` > `cur_cpl`.
- R6: A far call through a passing gate to a nonconforming destination (`gate_code_conf`=0) with `gate_code_dpl` < `cur_cpl` is permitted and the new level becomes `gate_code_dpl`.
- R7: A far jump through a passing gate is permitted only when the destination is conforming or `gate_code_dpl` equals `cur_cpl`; it never changes the level. A gated call to a conforming destination keeps `cur_cpl`.
- R8: A near transfer (`req_kind`=1) is permitted when `near_offset` <= `cs_limit` and is a GP fault otherwise; selector and descriptor fields, including the present bit, have no effect on it.
- R9: A data load or far transfer that passes every privilege and type rule but has `tgt_present`=0 gets fault class NP; a privilege or type failure reports GP even when the descriptor is absent.
- R10: The verdict appears with `rsp_valid`=1 on the clock after a cycle with `req_valid`=1, and `rsp_valid` is 0 after a cycle without a request and while reset is held (reset also clears the other outputs to 0).
- R11: A data load or far transfer naming a system descriptor (`tgt_kind`=3) is a GP fault.
- R12: Fault classes are encoded 0 = none, 1 = GP, 2 = NP; `rsp_permit` is 1 exactly when the class is none; on any fault `rsp_new_cpl` equals `cur_cpl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | One request this cycle |
| req_kind | input | 2 | 0 data load, 1 near, 2 far jump, 3 far call |
| cur_cpl | input | 2 | Current privilege level |
| sel_rpl | input | 2 | Requestor level of the selector |
| tgt_kind | input | 2 | 0 data, 1 code, 2 call gate, 3 system |
| tgt_dpl | input | 2 | Descriptor level (gate level for a gate) |
| tgt_conf | input | 1 | Conforming flag of a directly named code segment |
| tgt_present | input | 1 | Present flag of the named descriptor |
| gate_code_dpl | input | 2 | Level of the code segment a gate leads to |
| gate_code_conf | input | 1 | Conforming flag of that code segment |
| near_offset | input | OFF_W | Destination offset of a near transfer |
| cs_limit | input | OFF_W | Cached code-segment limit (inclusive) |
| rsp_valid | output | 1 | Verdict valid |
| rsp_permit | output | 1 | Request allowed |
| rsp_fault | output | 2 | Fault class |
| rsp_new_cpl | output | 2 | Level after the request |

## Verification
Two judgements can fall on one request: the privilege/type verdict and the present check. The bench sweeps every combination of levels, target kinds, conforming flags and present bit, so privilege failures coincide with absent descriptors. The expected class is GP in that case and NP only when the privilege rules pass. The other overlap is a verdict leaving the register in the same cycle that the next request arrives. Requests are driven back to back with idle gaps between groups, and a behavioural model in the bench checks every clock for the right verdict in the right cycle and for no stale valid.

// File: rtl/segchk_pkg.sv
// Shared encodings for the segment privilege check unit.
// Assumes privilege levels are two bits, 0 most trusted.
package segchk_pkg;
    typedef logic [1:0] plvl_t;

    typedef enum logic [1:0] {
        RK_DATA_LOAD = 2'd0,
        RK_NEAR      = 2'd1,
        RK_FAR_JMP   = 2'd2,
        RK_FAR_CALL  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        TK_DATA      = 2'd0,
        TK_CODE      = 2'd1,
        TK_CALL_GATE = 2'd2,
        TK_SYSTEM    = 2'd3
    } tgt_kind_e;

    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_GP   = 2'd1,
        FC_NP   = 2'd2
    } fault_e;

    typedef struct packed {
        logic  ok;
        plvl_t new_cpl;
    } verdict_t;

    function automatic plvl_t pl_max(plvl_t a, plvl_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/segchk_direct.sv
// Privilege and type judgement for data-segment loads and for far
// transfers that name a code descriptor directly. Purely combinational.
// Assumes the caller only uses the result for those request kinds.
module segchk_direct
    import segchk_pkg::*;
(
    input  req_kind_e  kind,
    input  plvl_t      cpl,
    input  plvl_t      rpl,
    input  tgt_kind_e  tk,
    input  plvl_t      dpl,
    input  logic       conf,
    output verdict_t   verdict
);
    plvl_t eff_lvl;

    // Judge data loads by effective level and code targets by ring match.
    always_comb begin
        eff_lvl         = pl_max(cpl, rpl);
        verdict.ok      = 1'b0;
        verdict.new_cpl = cpl;
        if (kind == RK_DATA_LOAD) begin
            verdict.ok = (tk == TK_DATA) && (dpl >= eff_lvl);
        end else if (tk == TK_CODE) begin
            verdict.ok = conf ? (dpl <= cpl) : (dpl == cpl);
        end
    end
endmodule

// File: rtl/segchk_gate.sv
// Four-level judgement for far transfers through a call gate.
// Only a call may move to a more trusted ring; a jump keeps its ring.
// Assumes the gate level arrives as gate_dpl and the destination code
// segment's level and conforming flag as code_dpl / code_conf.
module segchk_gate
    import segchk_pkg::*;
(
    input  logic     is_call,
    input  plvl_t    cpl,
    input  plvl_t    rpl,
    input  plvl_t    gate_dpl,
    input  plvl_t    code_dpl,
    input  logic     code_conf,
    output verdict_t verdict
);
    logic gate_open;
    logic dest_ok;

    // Gate access first, then destination ring and transfer kind.
    always_comb begin
        gate_open       = gate_dpl >= pl_max(cpl, rpl);
        dest_ok         = 1'b0;
        verdict.new_cpl = cpl;
        if (code_dpl <= cpl) begin
            if (code_conf || code_dpl == cpl) begin
                dest_ok = 1'b1;
            end else if (is_call) begin
                dest_ok         = 1'b1;
                verdict.new_cpl = code_dpl;
            end
        end
        verdict.ok = gate_open && dest_ok;
        if (!verdict.ok) begin
            verdict.new_cpl = cpl;
        end
    end
endmodule

// File: rtl/segchk_limit.sv
// Near-transfer check: destination offset against the cached,
// inclusive code-segment limit. Combinational.
module segchk_limit #(
    parameter int OFF_W = 32
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [OFF_W-1:0] limit,
    output logic             in_range
);
    // Inclusive upper bound compare.
    always_comb begin
        in_range = (offset <= limit);
    end
endmodule

// File: rtl/seg_priv_check.sv
// Segment privilege check unit, top level. Picks the judgement for the
// request kind, applies the present check after privilege and type,
// and registers the verdict one clock after the request strobe.
// Assumes descriptors arrive decoded and at most one request per cycle.
module seg_priv_check
    import segchk_pkg::*;
#(
    parameter int OFF_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [1:0]       cur_cpl,
    input  logic [1:0]       sel_rpl,
    input  logic [1:0]       tgt_kind,
    input  logic [1:0]       tgt_dpl,
    input  logic             tgt_conf,
    input  logic             tgt_present,
    input  logic [1:0]       gate_code_dpl,
    input  logic             gate_code_conf,
    input  logic [OFF_W-1:0] near_offset,
    input  logic [OFF_W-1:0] cs_limit,
    output logic             rsp_valid,
    output logic             rsp_permit,
    output logic [1:0]       rsp_fault,
    output logic [1:0]       rsp_new_cpl
);
    req_kind_e kind;
    tgt_kind_e tk;
    verdict_t  v_direct;
    verdict_t  v_gate;
    logic      near_ok;
    logic      priv_ok;
    fault_e    fault_d;
    plvl_t     cpl_d;

    assign kind = req_kind_e'(req_kind);
    assign tk   = tgt_kind_e'(tgt_kind);

    segchk_direct u_direct (
        .kind    (kind),
        .cpl     (cur_cpl),
        .rpl     (sel_rpl),
        .tk      (tk),
        .dpl     (tgt_dpl),
        .conf    (tgt_conf),
        .verdict (v_direct)
    );

    segchk_gate u_gate (
        .is_call   (kind == RK_FAR_CALL),
        .cpl       (cur_cpl),
        .rpl       (sel_rpl),
        .gate_dpl  (tgt_dpl),
        .code_dpl  (gate_code_dpl),
        .code_conf (gate_code_conf),
        .verdict   (v_gate)
    );

    segchk_limit #(.OFF_W(OFF_W)) u_limit (
        .offset   (near_offset),
        .limit    (cs_limit),
        .in_range (near_ok)
    );

    // Select the judgement, then rank GP ahead of not-present.
    always_comb begin
        cpl_d = cur_cpl;
        if (kind == RK_NEAR) begin
            priv_ok = near_ok;
        end else if (kind != RK_DATA_LOAD && tk == TK_CALL_GATE) begin
            priv_ok = v_gate.ok;
            cpl_d   = v_gate.new_cpl;
        end else begin
            priv_ok = v_direct.ok;
        end
        if (!priv_ok) begin
            fault_d = FC_GP;
            cpl_d   = cur_cpl;
        end else if (kind != RK_NEAR && !tgt_present) begin
            fault_d = FC_NP;
            cpl_d   = cur_cpl;
        end else begin
            fault_d = FC_NONE;
        end
    end

    // Register the verdict one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_permit  <= 1'b0;
            rsp_fault   <= FC_NONE;
            rsp_new_cpl <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_permit  <= (fault_d == FC_NONE);
                rsp_fault   <= fault_d;
                rsp_new_cpl <= cpl_d;
            end
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid) else $error("AST_RSP_FOLLOWS_REQ"); // R10

    AST_NO_STALE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid) else $error("AST_NO_STALE_RSP"); // R10

    AST_PERMIT_MATCHES_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_permit == (rsp_fault == FC_NONE))) else $error("AST_PERMIT_MATCHES_CLASS"); // R12

    AST_RING_NEVER_WEAKENS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_new_cpl <= $past(cur_cpl))) else $error("AST_RING_NEVER_WEAKENS"); // R6

    AST_NEAR_NEVER_NP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind) == RK_NEAR) |-> (rsp_fault != FC_NP)) else $error("AST_NEAR_NEVER_NP"); // R8

    AST_JMP_KEEPS_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_kind) == RK_FAR_JMP) |-> (rsp_new_cpl == $past(cur_cpl))) else $error("AST_JMP_KEEPS_RING"); // R7

    AST_NP_NEEDS_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FC_NP) |-> !$past(tgt_present)) else $error("AST_NP_NEEDS_ABSENT"); // R9
endmodule

// File: tb/seg_priv_check_tb.sv
module seg_priv_check_tb;
    localparam int OFF_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_kind = '0;
    logic [1:0]       cur_cpl = '0;
    logic [1:0]       sel_rpl = '0;
    logic [1:0]       tgt_kind = '0;
    logic [1:0]       tgt_dpl = '0;
    logic             tgt_conf = 1'b0;
    logic             tgt_present = 1'b0;
    logic [1:0]       gate_code_dpl = '0;
    logic             gate_code_conf = 1'b0;
    logic [OFF_W-1:0] near_offset = '0;
    logic [OFF_W-1:0] cs_limit = '0;
    logic             rsp_valid;
    logic             rsp_permit;
    logic [1:0]       rsp_fault;
    logic [1:0]       rsp_new_cpl;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        bit    v;
        int    permit;
        int    fault;
        int    ncpl;
        string tag;
    } exp_s;
    exp_s q[$];

    always #10 clk = ~clk;

    seg_priv_check #(.OFF_W(OFF_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .cur_cpl(cur_cpl), .sel_rpl(sel_rpl), .tgt_kind(tgt_kind), .tgt_dpl(tgt_dpl),
        .tgt_conf(tgt_conf), .tgt_present(tgt_present), .gate_code_dpl(gate_code_dpl),
        .gate_code_conf(gate_code_conf), .near_offset(near_offset), .cs_limit(cs_limit),
        .rsp_valid(rsp_valid), .rsp_permit(rsp_permit), .rsp_fault(rsp_fault),
        .rsp_new_cpl(rsp_new_cpl)
    );

    // Behavioural reference: fault 0 none, 1 GP, 2 NP.
    function automatic exp_s model(int k, int cpl, int rpl, int tk, int conf, int dpl,
                                   int pres, int gdpl, int gconf,
                                   longint unsigned off, longint unsigned lim);
        exp_s e;
        int   eff;
        bit   ok;
        e.v = 1; e.ncpl = cpl; e.tag = "R1";
        eff = (cpl > rpl) ? cpl : rpl;
        ok = 0;
        if (k == 1) begin
            e.tag = "R8"; ok = (off <= lim);
        end else if (k == 0) begin
            if (tk == 0) begin e.tag = "R1"; ok = (dpl >= eff); end
            else if (tk == 3) e.tag = "R11";
            else e.tag = "R2";
        end else if (tk == 1) begin
            e.tag = conf ? "R4" : "R3";
            ok = conf ? (dpl <= cpl) : (dpl == cpl);
        end else if (tk == 2) begin
            e.tag = "R5";
            if (dpl >= eff && gdpl <= cpl) begin
                if (gconf || gdpl == cpl) begin
                    ok = 1; e.tag = (k == 2) ? "R7" : "R5";
                end else if (k == 3) begin
                    ok = 1; e.ncpl = gdpl; e.tag = "R6";
                end else begin
                    e.tag = "R7";
                end
            end
        end else begin
            e.tag = "R11";
        end
        if (!ok) begin
            e.fault = 1; e.ncpl = cpl;
        end else if (k != 1 && pres == 0) begin
            e.fault = 2; e.ncpl = cpl; e.tag = "R9";
        end else begin
            e.fault = 0;
        end
        e.permit = (e.fault == 0);
        return e;
    endfunction

    task automatic send(int k, int cpl, int rpl, int tk, int conf, int dpl, int pres,
                        int gdpl, int gconf, logic [OFF_W-1:0] off, logic [OFF_W-1:0] lim);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(k); cur_cpl = 2'(cpl); sel_rpl = 2'(rpl);
        tgt_kind = 2'(tk); tgt_conf = 1'(conf); tgt_dpl = 2'(dpl); tgt_present = 1'(pres);
        gate_code_dpl = 2'(gdpl); gate_code_conf = 1'(gconf);
        near_offset = off; cs_limit = lim;
        q.push_back(model(k, cpl, rpl, tk, conf, dpl, pres, gdpl, gconf, off, lim));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            exp_s e;
            @(negedge clk);
            req_valid = 1'b0;
            req_kind = 2'($urandom); cur_cpl = 2'($urandom); tgt_present = 1'($urandom);
            e.v = 0; e.permit = 0; e.fault = 0; e.ncpl = 0; e.tag = "R10";
            q.push_back(e);
        end
    endtask

    // Compare the registered verdict shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_s e;
            e = q.pop_front();
            checks++;
            if (!e.v) begin
                if (rsp_valid !== 1'b0) begin
                    failures++;
                    $display("FAIL R10 idle: rsp_valid=%0b expected 0", rsp_valid);
                end
            end else if (rsp_valid !== 1'b1 || rsp_permit !== 1'(e.permit) ||
                         rsp_fault !== 2'(e.fault) || rsp_new_cpl !== 2'(e.ncpl)) begin
                failures++;
                $display("FAIL R12/%s: valid=%0b permit=%0b fault=%0d cpl=%0d expected 1 %0d %0d %0d",
                         e.tag, rsp_valid, rsp_permit, rsp_fault, rsp_new_cpl,
                         e.permit, e.fault, e.ncpl);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        req_valid = 1'b1;
        @(posedge clk); #2;
        checks++;  // R10 reset state, request ignored under reset
        if (rsp_valid !== 0 || rsp_permit !== 0 || rsp_fault !== 0 || rsp_new_cpl !== 0) begin
            failures++;
            $display("FAIL R10 reset: %0b %0b %0d %0d expected 0 0 0 0",
                     rsp_valid, rsp_permit, rsp_fault, rsp_new_cpl);
        end
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);
        // Directed corners: R1 R3 R4 R6 R7 R9 R8 boundaries.
        send(0, 1, 2, 0, 0, 2, 1, 0, 0, 0, 0);
        send(0, 1, 3, 0, 0, 2, 1, 0, 0, 0, 0);
        send(3, 3, 0, 2, 0, 3, 1, 0, 0, 0, 0);
        send(2, 3, 0, 2, 0, 3, 1, 0, 0, 0, 0);
        send(2, 2, 0, 1, 1, 0, 1, 0, 0, 0, 0);
        send(3, 2, 2, 1, 0, 2, 0, 0, 0, 0, 0);
        send(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        send(1, 3, 3, 3, 0, 0, 0, 0, 0, 32'h0000_1000, 32'h0000_1000);
        send(1, 3, 3, 3, 0, 0, 0, 0, 0, 32'h0000_1001, 32'h0000_1000);
        send(1, 0, 0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        idle(3);
        // Exhaustive sweep of fields, back to back, gaps between kinds.
        for (int k = 0; k < 4; k++) begin
            for (int tk = 0; tk < 4; tk++)
            for (int conf = 0; conf < 2; conf++)
            for (int cpl = 0; cpl < 4; cpl++)
            for (int rpl = 0; rpl < 4; rpl++)
            for (int dpl = 0; dpl < 4; dpl++)
            for (int gdpl = 0; gdpl < 4; gdpl++)
            for (int gconf = 0; gconf < 2; gconf++)
            for (int pres = 0; pres < 2; pres++) begin
                logic [OFF_W-1:0] lim;
                logic [OFF_W-1:0] off;
                lim = OFF_W'($urandom);
                off = ($urandom % 3 == 0) ? lim + OFF_W'($urandom % 3) - 1 : OFF_W'($urandom);
                send(k, cpl, rpl, tk, conf, dpl, pres, gdpl, gconf, off, lim);
            end
            idle(2);
        end
        idle(2);
        @(posedge clk); #5;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule